// File: doc/BRIEF.md
# Match-and-Capture Timer

A 32-bit free-running timer for a peripheral subsystem. A prescale counter divides the clock, and each wrap of that counter advances the timer counter by one. Four match channels compare every new counter value against their own compare register. On a hit, a channel can raise a flag, force the counter back to zero, or halt counting, in any combination. Four capture channels watch external inputs through a synchronizer. On a chosen edge (rising, falling or either), a capture channel stores the counter value and can raise a flag.

Software drives the block through a flat word-addressed register port. Writes take effect at the clock edge. Reads are combinational from the current register state. A single interrupt line is high while any flag is pending. Flags are cleared by writing ones to the flag register.

Top module: `match_cap_timer`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: The word addresses are: flags 0, control 1, counter 2, prescale 3, prescale count 4, match config 5, compare 0..3 at 6..9, capture config 10, capture 0..3 at 11..14, and a 4-bit plain storage word at 15. Writable registers read back what was written. Capture words ignore writes.
- R3: With control bit 0 set and a prescale of 0, the counter advances by one on every clock. With bit 0 clear and bit 1 clear, the counter holds its value.
- R4: With prescale p, the prescale count runs 0..p and the counter advances once every p+1 clocks. A prescale count at or above p wraps to 0 on the next enabled clock.
- R5: While control bit 1 is set, the counter and the prescale count are held at 0, overriding software writes to them.
- R6: Match config bits 3n+2..3n are {stop, zero, flag}. When the counter advances onto the value of compare n and its flag bit is set, flag bit n is set. Without the flag bit it stays clear.
- R7: A hit on a channel with its zero bit set loads 0 into the counter instead of the compare value.
- R8: A hit on a channel with its stop bit set clears control bit 0. The counter keeps the compare value, or 0 when the zero bit is also set.
- R9: Matches are evaluated only when the counter advances, so a counter halted on a compare value raises no new flag.
- R10: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. A hardware set in the same cycle wins. `irq_o` is the OR of all flags.
- R11: A capture input passes two synchronizer flops. If it changes before clock edge k, capture n loads the counter value in effect after edge k+1. The load happens at edge k+2.
- R12: Capture config bits 3n and 3n+1 enable loading on rising and falling edges; both may be set. An edge whose enable is clear leaves the capture word unchanged.
- R13: Capture config bit 3n+2 sets flag bit 4+n on each load. With it clear, the load raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| cap_i | input | 4 | Capture inputs, asynchronous |
| irq_o | output | 1 | High while any flag is set |

## Verification
Register writes, counter advances, match flags, zeroing and stop all appear one edge after the cycle that causes them. For a match, the counter equals n exactly n edges after the enabling write. A capture needs three edges after the input changes and holds the counter value seen two edges after that change. The bench advances from just after a clock edge, drives inputs there and reads a couple of nanoseconds later. It reads the counter right before toggling a capture input, so every expected count is derived from that known edge offset.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NCH   = 4;
  localparam int unsigned AW    = 4;
  localparam int unsigned CFG_W = 3;

  localparam logic [AW-1:0] A_IR   = 4'd0;
  localparam logic [AW-1:0] A_CTRL = 4'd1;
  localparam logic [AW-1:0] A_TC   = 4'd2;
  localparam logic [AW-1:0] A_PR   = 4'd3;
  localparam logic [AW-1:0] A_PC   = 4'd4;
  localparam logic [AW-1:0] A_MCR  = 4'd5;
  localparam logic [AW-1:0] A_MR0  = 4'd6;
  localparam logic [AW-1:0] A_CCR  = 4'd10;
  localparam logic [AW-1:0] A_CR0  = 4'd11;
  localparam logic [AW-1:0] A_EXT  = 4'd15;

  typedef struct packed {
    logic stop;
    logic zero;
    logic flag;
  } mcfg_t;

  typedef struct packed {
    logic flag;
    logic fall;
    logic rise;
  } ccfg_t;
endpackage

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          hold_i,
  input  logic [DW-1:0] pr_i,
  input  logic          tc_we_i,
  input  logic          pc_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] mr_i [NCH],
  input  mcfg_t         mcfg_i [NCH],
  output logic [DW-1:0] tc_o,
  output logic [DW-1:0] pc_o,
  output logic [NCH-1:0] hit_flag_o,
  output logic          stop_o
);
  logic [DW-1:0]  tc_q, pc_q, tc_inc;
  logic           tick;
  logic [NCH-1:0] hit, zero_v, stop_v;

  // >= so a prescale lowered below the running count still wraps
  assign tick   = run_i & ~hold_i & (pc_q >= pr_i);
  assign tc_inc = tc_q + 1'b1;

  for (genvar g = 0; g < int'(NCH); g++) begin : g_cmp
    assign hit[g]        = tick & ~tc_we_i & (tc_inc == mr_i[g]);
    assign zero_v[g]     = hit[g] & mcfg_i[g].zero;
    assign stop_v[g]     = hit[g] & mcfg_i[g].stop;
    assign hit_flag_o[g] = hit[g] & mcfg_i[g].flag;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_q <= '0;
    else if (hold_i)  pc_q <= '0;
    else if (pc_we_i) pc_q <= wdata_i;
    else if (run_i)   pc_q <= tick ? '0 : pc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tc_q <= '0;
    else if (hold_i)  tc_q <= '0;
    else if (tc_we_i) tc_q <= wdata_i;
    else if (tick)    tc_q <= (|zero_v) ? '0 : tc_inc;
  end

  assign stop_o = |stop_v;
  assign tc_o   = tc_q;
  assign pc_o   = pc_q;
endmodule

// File: rtl/tmr_cap_chan.sv
module tmr_cap_chan
  import tmr_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned SYNC_N = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pin_i,
  input  ccfg_t         cfg_i,
  input  logic [DW-1:0] tc_i,
  output logic [DW-1:0] cr_o,
  output logic          load_o,
  output logic          flag_o
);
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q, lvl;
  logic [DW-1:0]     cr_q;

  assign lvl    = sync_q[SYNC_N-1];
  assign load_o = (lvl & ~prev_q & cfg_i.rise) | (~lvl & prev_q & cfg_i.fall);
  assign flag_o = load_o & cfg_i.flag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], pin_i};
      prev_q <= lvl;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cr_q <= '0;
    else if (load_o) cr_q <= tc_i;
  end

  assign cr_o = cr_q;
endmodule

// File: rtl/match_cap_timer.sv
module match_cap_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned SYNC_N = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic [NCH-1:0] cap_i,
  output logic          irq_o
);
  localparam int unsigned CW = CFG_W * NCH;
  localparam int unsigned FW = 2 * NCH;

  logic [1:0]      ctrl_q;
  logic [DW-1:0]   pr_q;
  logic [CW-1:0]   mcr_q, ccr_q;
  logic [NCH-1:0]  ext_q;
  logic [FW-1:0]   ir_q;
  logic [DW-1:0]   mr_q [NCH];
  mcfg_t           mcfg [NCH];
  ccfg_t           ccfg [NCH];
  logic [DW-1:0]   cr_w [NCH];
  logic [NCH*DW-1:0] cr_flat;
  logic [NCH-1:0]  cap_load_w, cap_flag_w, match_flag_w;
  logic [DW-1:0]   tc_w, pc_w;
  logic            stop_w;
  logic [FW-1:0]   ir_clr;

  function automatic logic wr_at(input logic [AW-1:0] a);
    return reg_we_i && (reg_addr_i == a);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      pr_q   <= '0;
      mcr_q  <= '0;
      ccr_q  <= '0;
      ext_q  <= '0;
    end else begin
      if (wr_at(A_CTRL))  ctrl_q    <= reg_wdata_i[1:0];
      else if (stop_w)    ctrl_q[0] <= 1'b0;
      if (wr_at(A_PR))    pr_q  <= reg_wdata_i;
      if (wr_at(A_MCR))   mcr_q <= reg_wdata_i[CW-1:0];
      if (wr_at(A_CCR))   ccr_q <= reg_wdata_i[CW-1:0];
      if (wr_at(A_EXT))   ext_q <= reg_wdata_i[NCH-1:0];
    end
  end

  // set beats write-1-clear in the same cycle
  assign ir_clr = wr_at(A_IR) ? reg_wdata_i[FW-1:0] : '0;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ir_q <= '0;
    else         ir_q <= (ir_q & ~ir_clr) | {cap_flag_w, match_flag_w};
  end
  assign irq_o = |ir_q;

  for (genvar g = 0; g < int'(NCH); g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        mr_q[g] <= '0;
      else if (wr_at(A_MR0 + AW'(g)))     mr_q[g] <= reg_wdata_i;
    end
    assign mcfg[g] = mcfg_t'(mcr_q[CFG_W*g +: CFG_W]);
    assign ccfg[g] = ccfg_t'(ccr_q[CFG_W*g +: CFG_W]);

    tmr_cap_chan #(.DW(DW), .SYNC_N(SYNC_N)) u_cap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (cap_i[g]),
      .cfg_i  (ccfg[g]),
      .tc_i   (tc_w),
      .cr_o   (cr_w[g]),
      .load_o (cap_load_w[g]),
      .flag_o (cap_flag_w[g])
    );
    assign cr_flat[DW*g +: DW] = cr_w[g];
  end

  tmr_count_core #(.DW(DW)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (ctrl_q[0]),
    .hold_i     (ctrl_q[1]),
    .pr_i       (pr_q),
    .tc_we_i    (wr_at(A_TC)),
    .pc_we_i    (wr_at(A_PC)),
    .wdata_i    (reg_wdata_i),
    .mr_i       (mr_q),
    .mcfg_i     (mcfg),
    .tc_o       (tc_w),
    .pc_o       (pc_w),
    .hit_flag_o (match_flag_w),
    .stop_o     (stop_w)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_IR:    reg_rdata_o = DW'(ir_q);
      A_CTRL:  reg_rdata_o = DW'(ctrl_q);
      A_TC:    reg_rdata_o = tc_w;
      A_PR:    reg_rdata_o = pr_q;
      A_PC:    reg_rdata_o = pc_w;
      A_MCR:   reg_rdata_o = DW'(mcr_q);
      A_CCR:   reg_rdata_o = DW'(ccr_q);
      A_EXT:   reg_rdata_o = DW'(ext_q);
      default: reg_rdata_o = '0;
    endcase
    for (int n = 0; n < int'(NCH); n++) begin
      if (reg_addr_i == A_MR0 + AW'(n)) reg_rdata_o = mr_q[n];
      if (reg_addr_i == A_CR0 + AW'(n)) reg_rdata_o = cr_w[n];
    end
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [AW-1:0]     reg_addr_i,
  input logic [1:0]        ctrl_q,
  input logic [DW-1:0]     pr_q,
  input logic [DW-1:0]     tc_q,
  input logic [DW-1:0]     pc_q,
  input logic [2*NCH-1:0]  ir_q,
  input logic              stop_evt,
  input logic [NCH-1:0]    cap_load,
  input logic [NCH*DW-1:0] cr_flat
);
  assert_idle_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q == 2'b00 && !(reg_we_i && reg_addr_i == A_TC)) |=> $stable(tc_q));

  assert_pc_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q == 2'b01 && pc_q >= pr_q && !(reg_we_i && reg_addr_i == A_PC)) |=> (pc_q == '0));

  assert_hold_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[1] |=> (tc_q == '0 && pc_q == '0));

  assert_stop_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ctrl_q[0]) && !$past(reg_we_i && reg_addr_i == A_CTRL)) |-> $past(stop_evt));

  assert_flag_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(ir_q) & ~ir_q)) |-> $past(reg_we_i && reg_addr_i == A_IR));

  assert_cap_source_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cr_flat) |-> $past(|cap_load));
endmodule

bind match_cap_timer tmr_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .ctrl_q     (ctrl_q),
  .pr_q       (pr_q),
  .tc_q       (tc_w),
  .pc_q       (pc_w),
  .ir_q       (ir_q),
  .stop_evt   (stop_w),
  .cap_load   (cap_load_w),
  .cr_flat    (cr_flat)
);

// File: tb/sim_match_cap_timer.sv
`timescale 1ns/1ps
module sim_match_cap_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  cap = '0;
  logic        irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  match_cap_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cap_i(cap), .irq_o(irq)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 16; a++) check_reg("R1 reset value", 4'(a), 32'h0);
    check("R1 irq at reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_regmap;
    wr(4'd3, 32'h55); wr(4'd5, 32'hABC); wr(4'd10, 32'h123); wr(4'd15, 32'hA);
    for (int n = 0; n < 4; n++) wr(4'(6 + n), 32'h1000 + 32'(n));
    wr(4'd12, 32'hDEAD);
    check_reg("R2 prescale readback", 4'd3, 32'h55);
    check_reg("R2 match config readback", 4'd5, 32'hABC);
    check_reg("R2 capture config readback", 4'd10, 32'h123);
    check_reg("R2 storage word readback", 4'd15, 32'hA);
    for (int n = 0; n < 4; n++) check_reg("R2 compare readback", 4'(6 + n), 32'h1000 + 32'(n));
    check_reg("R2 capture word ignores write", 4'd12, 32'h0);
    wr(4'd3, 0); wr(4'd5, 0); wr(4'd10, 0);
  endtask

  task automatic t_count;
    wr(4'd1, 2); wr(4'd3, 0); wr(4'd1, 1);
    step(10);
    check_reg("R3 counter after 10 enabled clocks", 4'd2, 32'd10);
    wr(4'd1, 0);
    step(5);
    check_reg("R3 counter holds when disabled", 4'd2, 32'd11);
  endtask

  task automatic t_prescale;
    wr(4'd1, 2); wr(4'd3, 3); wr(4'd1, 1);
    step(12);
    check_reg("R4 counter with prescale 3", 4'd2, 32'd3);
    check_reg("R4 prescale count at wrap", 4'd4, 32'd0);
    step(2);
    check_reg("R4 prescale count mid period", 4'd4, 32'd2);
    check_reg("R4 counter mid period", 4'd2, 32'd3);
    wr(4'd3, 0);
    step(4);
    check_reg("R4 prescale count after lowering prescale", 4'd4, 32'd0);
  endtask

  task automatic t_hold;
    wr(4'd1, 3);
    step(1);
    check_reg("R5 counter held", 4'd2, 32'd0);
    wr(4'd2, 77);
    step(5);
    check_reg("R5 counter ignores write while held", 4'd2, 32'd0);
    check_reg("R5 prescale count held", 4'd4, 32'd0);
  endtask

  task automatic t_match_zero;
    wr(4'd1, 2); wr(4'd3, 0); wr(4'd6, 5); wr(4'd5, 32'h3); wr(4'd1, 1);
    step(4);
    check_reg("R6 no flag before match", 4'd0, 32'h0);
    step(1);
    check_reg("R7 counter zeroed on match", 4'd2, 32'd0);
    check_reg("R6 match flag 0 set", 4'd0, 32'h1);
    check("R10 irq follows flag", {31'b0, irq}, 32'h1);
    step(2);
    check_reg("R7 counter restarts", 4'd2, 32'd2);
  endtask

  task automatic t_w1c;
    wr(4'd1, 2);
    wr(4'd0, 32'h0);
    check_reg("R10 zero write keeps flag", 4'd0, 32'h1);
    wr(4'd0, 32'h1);
    check_reg("R10 one write clears flag", 4'd0, 32'h0);
    check("R10 irq low when no flag", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_stop;
    wr(4'd5, 32'h28); wr(4'd7, 4); wr(4'd1, 1);
    step(4);
    check_reg("R8 counter stays on compare value", 4'd2, 32'd4);
    check_reg("R8 enable cleared by stop", 4'd1, 32'd0);
    check_reg("R6 match flag 1 set", 4'd0, 32'h2);
    wr(4'd0, 32'h2);
    step(6);
    check_reg("R9 no re-flag while halted", 4'd0, 32'h0);
    check_reg("R9 counter still halted", 4'd2, 32'd4);
  endtask

  task automatic t_stop_zero;
    wr(4'd1, 2); wr(4'd5, 32'h1C0); wr(4'd8, 3); wr(4'd1, 1);
    step(3);
    check_reg("R8 stop with zero gives 0", 4'd2, 32'd0);
    check_reg("R8 enable cleared", 4'd1, 32'd0);
    check_reg("R6 match flag 2 set", 4'd0, 32'h4);
    step(3);
    check_reg("R8 counter stays 0", 4'd2, 32'd0);
    wr(4'd0, 32'h4);
  endtask

  task automatic t_no_flag;
    wr(4'd1, 2); wr(4'd5, 32'h400); wr(4'd9, 2); wr(4'd1, 1);
    step(5);
    check_reg("R7 counter cycling through zero", 4'd2, 32'd1);
    check_reg("R6 no flag without flag bit", 4'd0, 32'h0);
    wr(4'd1, 2); wr(4'd5, 0);
  endtask

  // toggle capture input ch to lvl; expect load of counter+2 when exp_load
  task automatic cap_edge(input int ch, input logic lvl, input bit exp_load, input string req);
    logic [31:0] t0, old;
    rd(4'(11 + ch), old);
    rd(4'd2, t0);
    cap[ch] = lvl;
    step(3);
    check_reg(req, 4'(11 + ch), exp_load ? t0 + 32'd2 : old);
  endtask

  task automatic t_capture;
    wr(4'd1, 2); wr(4'd10, 32'h2D5); wr(4'd1, 1);
    step(3);
    cap_edge(0, 1'b1, 1'b1, "R11 rising load on capture 0");
    check_reg("R13 capture flag 0 set", 4'd0, 32'h10);
    wr(4'd0, 32'h10);
    cap_edge(0, 1'b0, 1'b0, "R12 falling ignored on capture 0");
    check_reg("R13 no flag on ignored edge", 4'd0, 32'h0);
    cap_edge(1, 1'b1, 1'b0, "R12 rising ignored on capture 1");
    cap_edge(1, 1'b0, 1'b1, "R12 falling load on capture 1");
    cap_edge(2, 1'b1, 1'b1, "R12 both edges rising on capture 2");
    step(2);
    cap_edge(2, 1'b0, 1'b1, "R12 both edges falling on capture 2");
    cap_edge(3, 1'b1, 1'b1, "R11 rising load on capture 3");
    check_reg("R13 no flag without flag bit", 4'd0, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_regmap();
    t_count();
    t_prescale();
    t_hold();
    t_match_zero();
    t_w1c();
    t_stop();
    t_stop_zero();
    t_no_flag();
    t_capture();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule